// File: doc/BRIEF.md
# Transmitter Power Mode Controller

This block picks the operating mode of a serial display transmitter from three inputs: an enable pin, the pixel clock itself and a stable indication from the PLL. The pixel clock is treated as a data signal in the domain of a free-running reference clock. It is brought into that domain through a synchronizer, and its rising edges are counted over a fixed window of reference cycles. At the end of each window the count is sorted into one of three classes: slow (below the 500 kHz threshold), fast (above the 3 MHz threshold) or in between.

From the enable level, the window result and the lock input, a four-state machine selects one mode: shutdown, standby, acquire or transmit. The mode then sets the enables for the PLL, the serializer, the tristate output drivers and the frequency monitor. When the lower threshold is crossed upwards but the upper one is not, the block keeps its current mode. This gives hysteresis between standby and the active modes. In transmit mode the block forwards a synchronized copy of the pixel clock, so that the clock lane runs at the pixel rate.

All thresholds are parameters given in kilohertz and are turned into edge counts for the chosen window length and reference frequency. With the defaults (100 MHz reference, 2000-cycle window) the slow limit is 10 edges and the fast limit is 60 edges.

Top module: `txpwr_mode_ctrl`

## Requirements
- R1: After reset, mode_o is 0 (shutdown) and pll_en_o, ser_en_o, drv_en_o, mon_en_o and pix_fwd_o are all low. The mode encoding is: 0 shutdown, 1 standby, 2 acquire, 3 transmit.
- R2: If en_i is low at a reference clock edge, mode_o is 0 after that edge, whatever the previous mode. In shutdown all four enables are low, and neither the pixel clock nor pll_stable_i has any effect.
- R3: Dropping en_i clears the frequency measurement. After en_i rises, the block is in standby (mode 1) one cycle later and makes no frequency decision until a full window of WIN_CYC reference cycles has passed.
- R4: In standby only mon_en_o is high. A window count below the slow limit keeps the block in standby, or sends it there.
- R5: In standby, a window count above the fast limit moves the block to acquire (mode 2). In acquire pll_en_o is high and ser_en_o, drv_en_o are low.
- R6: A window count between the slow and fast limits (inclusive) leaves the mode unchanged, in standby as well as in transmit.
- R7: In acquire with pll_stable_i high, the block is in transmit (mode 3) after the next edge. In transmit, pll_en_o, ser_en_o, drv_en_o and mon_en_o are all high.
- R8: In transmit, pll_stable_i low moves the block back to acquire after the next edge, and drv_en_o goes low.
- R9: A slow window result in acquire or transmit moves the block to standby, whatever the state of pll_stable_i.
- R10: pix_fwd_o carries the synchronized pixel clock (the same edge rate) while the mode is transmit, and is held low in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Free-running reference clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Transmitter enable level |
| pix_clk_i | input | 1 | Pixel clock, sampled as asynchronous data |
| pll_stable_i | input | 1 | PLL stable (lock) indication |
| mode_o | output | 2 | Current mode (0 shutdown, 1 standby, 2 acquire, 3 transmit) |
| pll_en_o | output | 1 | PLL enable |
| ser_en_o | output | 1 | Serializer enable |
| drv_en_o | output | 1 | Output driver enable (low means high impedance) |
| mon_en_o | output | 1 | Frequency monitor active |
| pix_fwd_o | output | 1 | Forwarded pixel clock copy |

## Verification
A wrong mode register shows up at once on the enable outputs, because every enable is decoded straight from the mode. An enable or lock reaction that goes wrong is therefore visible one reference cycle after the input changes. A fault in the measurement path only shows at the end of a window: a miscounted or uncleared edge counter moves the mode at the wrong window boundary, or fails to move it. The bench therefore checks the mode several windows after each frequency change, and once halfway through the first window after re-enable. The forwarded clock is checked by counting its edges over a full window in transmit and over a shorter span in acquire.

// File: rtl/txpwr_pkg.sv
package txpwr_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_ACQ  = 2'd2,
    MODE_TX   = 2'd3
  } txpwr_mode_e;

  typedef struct packed {
    logic vld;
    logic slow;
    logic fast;
  } txpwr_verdict_t;

endpackage

// File: rtl/txpwr_rst_sync.sv
module txpwr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) chain_q <= '0;
    else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/txpwr_pix_sync.sv
module txpwr_pix_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pix_async,
  output logic pix_lvl,
  output logic pix_rise
);

  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q, prev_d;

  always_comb begin
    if (clr) begin
      sync_d = '0;
      prev_d = 1'b0;
    end else begin
      sync_d = {sync_q[STAGES-2:0], pix_async};
      prev_d = sync_q[STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign pix_lvl  = sync_q[STAGES-1];
  assign pix_rise = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/txpwr_freq_meter.sv
module txpwr_freq_meter
  import txpwr_pkg::*;
#(
  parameter int WIN_CYC = 2000,
  parameter int LO_CNT  = 10,
  parameter int HI_CNT  = 60
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           rise,
  output txpwr_verdict_t verdict
);

  localparam int WIN_W = $clog2(WIN_CYC);
  localparam int CNT_W = $clog2(WIN_CYC + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);
  localparam logic [CNT_W-1:0] LO_LIM   = CNT_W'(LO_CNT);
  localparam logic [CNT_W-1:0] HI_LIM   = CNT_W'(HI_CNT);

  logic [WIN_W-1:0] win_q, win_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_sum;
  txpwr_verdict_t   ver_q, ver_d;
  logic             win_end;

  assign win_end = (win_q == WIN_LAST);
  assign cnt_sum = cnt_q + CNT_W'(rise);

  always_comb begin
    win_d = win_q;
    cnt_d = cnt_q;
    ver_d = '0;
    if (clr) begin
      win_d = '0;
      cnt_d = '0;
    end else if (win_end) begin
      win_d      = '0;
      cnt_d      = '0;
      ver_d.vld  = 1'b1;
      ver_d.slow = (cnt_sum < LO_LIM);
      ver_d.fast = (cnt_sum > HI_LIM);
    end else begin
      win_d = win_q + 1'b1;
      cnt_d = cnt_sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
      ver_q <= '0;
    end else begin
      win_q <= win_d;
      cnt_q <= cnt_d;
      ver_q <= ver_d;
    end
  end

  assign verdict = ver_q;

endmodule

// File: rtl/txpwr_mode_fsm.sv
module txpwr_mode_fsm
  import txpwr_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic           lock,
  input  txpwr_verdict_t verdict,
  output txpwr_mode_e    mode
);

  txpwr_mode_e state_q, state_d;
  logic        go_slow, go_fast;

  assign go_slow = verdict.vld & verdict.slow;
  assign go_fast = verdict.vld & verdict.fast;

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = MODE_OFF;
    end else begin
      unique case (state_q)
        MODE_OFF:  state_d = MODE_IDLE;
        MODE_IDLE: if (go_fast) state_d = MODE_ACQ;
        MODE_ACQ: begin
          if (go_slow)   state_d = MODE_IDLE;
          else if (lock) state_d = MODE_TX;
        end
        MODE_TX: begin
          if (go_slow)    state_d = MODE_IDLE;
          else if (!lock) state_d = MODE_ACQ;
        end
        default: state_d = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MODE_OFF;
    else        state_q <= state_d;
  end

  assign mode = state_q;

endmodule

// File: rtl/txpwr_mode_ctrl.sv
module txpwr_mode_ctrl
  import txpwr_pkg::*;
#(
  parameter int REF_KHZ     = 100000,
  parameter int WIN_CYC     = 2000,
  parameter int SLOW_KHZ    = 500,
  parameter int FAST_KHZ    = 3000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_ref_i,
  input  logic       rst_n_i,
  input  logic       en_i,
  input  logic       pix_clk_i,
  input  logic       pll_stable_i,
  output logic [1:0] mode_o,
  output logic       pll_en_o,
  output logic       ser_en_o,
  output logic       drv_en_o,
  output logic       mon_en_o,
  output logic       pix_fwd_o
);

  localparam int LO_CNT = (SLOW_KHZ * WIN_CYC) / REF_KHZ;
  localparam int HI_CNT = (FAST_KHZ * WIN_CYC) / REF_KHZ;

  logic           rst_sync_n;
  logic           meter_clr;
  logic           pix_lvl, pix_rise;
  txpwr_verdict_t verdict;
  txpwr_mode_e    mode;
  logic           fwd_q, fwd_d;

  assign meter_clr = ~en_i;

  txpwr_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk_ref_i),
    .rst_n_async (rst_n_i),
    .rst_n_sync  (rst_sync_n)
  );

  txpwr_pix_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk_ref_i),
    .rst_n     (rst_sync_n),
    .clr       (meter_clr),
    .pix_async (pix_clk_i),
    .pix_lvl   (pix_lvl),
    .pix_rise  (pix_rise)
  );

  txpwr_freq_meter #(
    .WIN_CYC (WIN_CYC),
    .LO_CNT  (LO_CNT),
    .HI_CNT  (HI_CNT)
  ) u_meter (
    .clk     (clk_ref_i),
    .rst_n   (rst_sync_n),
    .clr     (meter_clr),
    .rise    (pix_rise),
    .verdict (verdict)
  );

  txpwr_mode_fsm u_fsm (
    .clk     (clk_ref_i),
    .rst_n   (rst_sync_n),
    .en      (en_i),
    .lock    (pll_stable_i),
    .verdict (verdict),
    .mode    (mode)
  );

  assign fwd_d = (mode == MODE_TX) & pix_lvl;

  always_ff @(posedge clk_ref_i or negedge rst_sync_n) begin
    if (!rst_sync_n) fwd_q <= 1'b0;
    else             fwd_q <= fwd_d;
  end

  assign mode_o    = mode;
  assign pll_en_o  = (mode == MODE_ACQ) | (mode == MODE_TX);
  assign ser_en_o  = (mode == MODE_TX);
  assign drv_en_o  = (mode == MODE_TX);
  assign mon_en_o  = (mode != MODE_OFF);
  assign pix_fwd_o = fwd_q;

endmodule

// File: rtl/txpwr_mode_chk.sv
module txpwr_mode_chk
  import txpwr_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        lock,
  input logic        vld,
  input logic        slow,
  input logic        fast,
  input logic [1:0]  mode,
  input logic        pix_fwd
);

  a_r2_disable_shuts: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (mode == MODE_OFF));

  a_r5_idle_needs_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MODE_IDLE && !(vld && fast)) |=> (mode == MODE_IDLE));

  a_r7_lock_advances: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MODE_ACQ && lock && !(vld && slow)) |=> (mode == MODE_TX));

  a_r8_lock_loss: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mode == MODE_TX && !lock && !(vld && slow)) |=> (mode == MODE_ACQ));

  a_r9_slow_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (en && vld && slow) |=> (mode == MODE_IDLE));

  a_r10_fwd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_TX) |=> !pix_fwd);

endmodule

bind txpwr_mode_ctrl txpwr_mode_chk u_chk (
  .clk     (clk_ref_i),
  .rst_n   (rst_sync_n),
  .en      (en_i),
  .lock    (pll_stable_i),
  .vld     (verdict.vld),
  .slow    (verdict.slow),
  .fast    (verdict.fast),
  .mode    (mode_o),
  .pix_fwd (pix_fwd_o)
);

// File: tb/sim_txpwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_txpwr_mode_ctrl;

  localparam int WIN = 2000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic       pix;
  logic       lock;
  logic [1:0] mode;
  logic       pll_en, ser_en, drv_en, mon_en, pix_fwd;

  int pix_half;
  int total = 0;
  int bad   = 0;

  typedef struct {
    string      req;
    logic [1:0] mode;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  txpwr_mode_ctrl u0 (
    .clk_ref_i    (clk),
    .rst_n_i      (rst_n),
    .en_i         (en),
    .pix_clk_i    (pix),
    .pll_stable_i (lock),
    .mode_o       (mode),
    .pll_en_o     (pll_en),
    .ser_en_o     (ser_en),
    .drv_en_o     (drv_en),
    .mon_en_o     (mon_en),
    .pix_fwd_o    (pix_fwd)
  );

  initial begin
    pix = 1'b0;
    forever begin
      if (pix_half == 0) begin
        pix = 1'b0;
        #7;
      end else begin
        #(pix_half) pix = ~pix;
      end
    end
  end

  // monitor: pops expected mode and compares mode plus decoded enables
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [4:0] got, want;
      e = exp_q.pop_front();
      want = {e.mode,
              (e.mode == 2'd2) || (e.mode == 2'd3),
              e.mode == 2'd3,
              e.mode != 2'd0};
      got  = {mode, pll_en, ser_en, mon_en};
      total++;
      if (got !== want || drv_en !== (e.mode == 2'd3)) begin
        bad++;
        $display("FAIL %s: mode/pll/ser/mon=%b drv=%b expected %b drv=%b",
                 e.req, got, drv_en, want, e.mode == 2'd3);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [1:0] m);
    exp_t e;
    e.req  = req;
    e.mode = m;
    @(posedge clk);
    exp_q.push_back(e);
    wait (exp_q.size() == 0);
  endtask

  task automatic fwd_rate(input string req, input int span, input int lo, input int hi);
    int   n = 0;
    logic prev = pix_fwd;
    repeat (span) begin
      @(negedge clk);
      if (pix_fwd && !prev) n++;
      prev = pix_fwd;
    end
    total++;
    if (n < lo || n > hi) begin
      bad++;
      $display("FAIL %s: pix_fwd edges=%0d expected %0d..%0d", req, n, lo, hi);
    end
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: run incomplete, expected end before limit");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; lock = 1'b0; pix_half = 0;
    cyc(4);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 reset state", 2'd0);

    // R2: disabled, fast pixel clock and lock ignored
    pix_half = 50; lock = 1'b1;
    cyc(3 * WIN);
    chk("R2 shutdown ignores clock and lock", 2'd0);
    lock = 1'b0; pix_half = 0;

    // R4: enable with stopped pixel clock
    cyc(1); en = 1'b1;
    chk("R3 standby one cycle after enable", 2'd1);
    cyc(3 * WIN);
    chk("R4 stopped clock stays standby", 2'd1);

    // R6: mid-band frequency in standby
    pix_half = 500;
    cyc(3 * WIN);
    chk("R6 mid band holds standby", 2'd1);

    // R5: fast clock, no lock
    pix_half = 50;
    cyc(3 * WIN);
    chk("R5 fast clock enters acquire", 2'd2);
    fwd_rate("R10 no forwarded clock in acquire", 500, 0, 0);

    // R7: lock
    lock = 1'b1;
    chk("R7 lock moves to transmit", 2'd3);
    fwd_rate("R10 forwarded clock rate in transmit", WIN, 190, 210);

    // R8: lock lost
    cyc(1); lock = 1'b0;
    chk("R8 lock loss back to acquire", 2'd2);
    cyc(1); lock = 1'b1;
    chk("R7 relock to transmit", 2'd3);

    // R6: mid band in transmit
    pix_half = 500;
    cyc(3 * WIN);
    chk("R6 mid band holds transmit", 2'd3);

    // R9: slow clock with lock still high
    pix_half = 0;
    cyc(3 * WIN);
    chk("R9 slow clock forces standby despite lock", 2'd1);
    fwd_rate("R10 no forwarded clock in standby", 300, 0, 0);

    // back to transmit, then drop enable
    pix_half = 50;
    cyc(3 * WIN);
    chk("R5 fast clock again reaches transmit", 2'd3);
    cyc(1); en = 1'b0;
    chk("R2 disable from transmit within one cycle", 2'd0);

    // R3: re-enable with fast clock, no early decision
    cyc(5); en = 1'b1;
    chk("R3 standby right after re-enable", 2'd1);
    cyc(WIN / 2);
    chk("R3 no decision before full window", 2'd1);
    cyc(3 * WIN);
    chk("R3 transmit after windows elapse", 2'd3);

    cyc(5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule